// File: doc/BRIEF.md
# Programmable pin mapping and side-set unit

This block sits next to a small I/O state-machine core and turns the core's pin write requests into updates of a 32-bit pin-value latch and a 32-bit pin-direction latch. A 32-bit control word gives each kind of write its own base pin and pin count. The kinds are a wide data write, a narrow five-bit immediate write and side-set. Writes always place data bit 0 on the base pin and wrap pin numbers modulo 32. Pins outside the selected window keep their latched value.

Every instruction carries a 5-bit timing field. A programmable boundary splits this field into side-set bits in its upper part and a delay count in its lower part. An optional enable mode turns the topmost side-set bit into a gate. While a non-zero delay counts down, the block raises a stall output, and it ignores any instruction presented during the stall. The block also gives the core a rotated view of the input pins, so that a chosen pin lands on bit 0.

The core presents one instruction per cycle with `ins_valid`. The core should hold off while `stall` is high.

Top module: `pinmap_unit`

## Requirements
- R1: After a synchronous reset, the control word reads 0x1400_0000, `pin_val` and `pin_dir` are all zero, and `stall` is low.
- R2: Control word layout is wide base [4:0], narrow base [9:5], side-set base [14:10], input base [19:15], wide count [25:20], narrow count [28:26], side-set count [31:29]. A write via `cfg_we` reads back on `cfg_rdata` from the next cycle on. An instruction in the same cycle as a write still uses the old word.
- R3: Op code 1 writes `pin_val` and op code 2 writes `pin_dir`. Either one writes wide-count consecutive pins from the wide base, with `wr_data` bit i going to pin (base+i) mod 32. A count above 32 acts as 32 and a count of 0 writes nothing. Other pins keep their values. The result is visible in the cycle after acceptance.
- R4: Op code 3 writes `pin_val` and op code 4 writes `pin_dir`. Either one uses `wr_data[4:0]` over narrow-count pins from the narrow base, with wrap modulo 32. A count above 5 acts as 5.
- R5: With side-set count N (values above 5 act as 5), the top N bits of `ins_field` are side-set data. Their lowest bit drives `pin_val` at the side-set base, and higher bits drive consecutively higher pins modulo 32. Side-set is applied on every accepted instruction when N is at least 1.
- R6: With `ss_gate` high and N at least 1, `ins_field[4]` is an enable rather than data. The N-1 bits below it drive pins, and only when the enable is 1.
- R7: When side-set and a wide or narrow write to `pin_val` hit the same pin in one accepted instruction, the side-set bit wins.
- R8: The low 5-N bits of `ins_field` are a delay D. `stall` is high for exactly D cycles, starting in the cycle after acceptance, and N=5 gives no delay.
- R9: An instruction presented while `stall` is high is ignored. The latches do not change during the stall.
- R10: `in_view` bit i equals `pins_in[(input base + i) mod 32]`, combinationally.
- R11: Op codes 0, 5, 6 and 7 write neither latch, except through side-set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write enable |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Stored control word |
| ins_valid | input | 1 | Instruction presented this cycle |
| ins_op | input | 3 | Pin write kind (0 none, 1 wide to values, 2 wide to directions, 3 narrow to values, 4 narrow to directions) |
| wr_data | input | 32 | Write data; narrow writes use bits 4:0 |
| ins_field | input | 5 | Delay / side-set field |
| ss_gate | input | 1 | Top side-set bit acts as enable |
| pins_in | input | 32 | Input pin levels |
| in_view | output | 32 | Rotated input view |
| pin_val | output | 32 | Pin value latch |
| pin_dir | output | 32 | Pin direction latch |
| stall | output | 1 | Delay countdown active |

## Verification
The assertions watch three things on every cycle: latches holding still through a stall, a stall beginning exactly when an accepted instruction carries a non-zero delay, and the direction latch staying untouched by value-only writes. They also check control-word readback after a write and the absence of delay when all five field bits are side-set. Only the bench scenarios can show that the right pins move. That covers wrap-around at pin 31, clamped counts, side-set winning a collision, the gated enable mode and the exact stall length, which the behavioural model compares on each clock.

// File: rtl/pinmap_pkg.sv
package pinmap_pkg;

    localparam int PIN_W   = 32;
    localparam int IDX_W   = $clog2(PIN_W);
    localparam int FIELD_W = 5;
    localparam int FCNT_W  = $clog2(FIELD_W + 1);
    localparam int WCNT_W  = IDX_W + 1;
    localparam logic [31:0] CFG_RESET = 32'h1400_0000;

    typedef struct packed {
        logic [FCNT_W-1:0] ss_cnt;
        logic [FCNT_W-1:0] nar_cnt;
        logic [WCNT_W-1:0] wide_cnt;
        logic [IDX_W-1:0]  in_base;
        logic [IDX_W-1:0]  ss_base;
        logic [IDX_W-1:0]  nar_base;
        logic [IDX_W-1:0]  wide_base;
    } cfg_t;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_WIDE_VAL = 3'd1,
        OP_WIDE_DIR = 3'd2,
        OP_NAR_VAL  = 3'd3,
        OP_NAR_DIR  = 3'd4
    } op_e;

    typedef struct packed {
        logic [PIN_W-1:0] mask;
        logic [PIN_W-1:0] data;
    } wr_t;

    function automatic logic [PIN_W-1:0] rotl(input logic [PIN_W-1:0] x,
                                              input logic [IDX_W-1:0] s);
        logic [2*PIN_W-1:0] dbl;
        dbl = {x, x} >> (PIN_W - int'(s));
        return dbl[PIN_W-1:0];
    endfunction

    function automatic logic [PIN_W-1:0] rotr(input logic [PIN_W-1:0] x,
                                              input logic [IDX_W-1:0] s);
        logic [2*PIN_W-1:0] dbl;
        dbl = {x, x} >> s;
        return dbl[PIN_W-1:0];
    endfunction

    function automatic logic [PIN_W-1:0] win_mask(input logic [IDX_W-1:0] base,
                                                  input logic [WCNT_W-1:0] cnt);
        logic [2*PIN_W-1:0] ones;
        logic [WCNT_W-1:0]  c;
        c    = (int'(cnt) > PIN_W) ? WCNT_W'(PIN_W) : cnt;
        ones = (64'(1) << c) - 64'(1);
        return rotl(ones[PIN_W-1:0], base);
    endfunction

    function automatic logic [FCNT_W-1:0] clamp_f(input logic [FCNT_W-1:0] c);
        return (int'(c) > FIELD_W) ? FCNT_W'(FIELD_W) : c;
    endfunction

endpackage

// File: rtl/pinmap_cfg.sv
module pinmap_cfg
    import pinmap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [31:0] wdata,
    output cfg_t        cfg,
    output logic [31:0] rdata
);
    logic [31:0] word_q;

    always_ff @(posedge clk) begin
        if (rst)     word_q <= CFG_RESET;
        else if (we) word_q <= wdata;
    end

    assign cfg   = cfg_t'(word_q);
    assign rdata = word_q;

    p_cfg_readback_r2: assert property (@(posedge clk) disable iff (rst)
        we |=> (rdata == $past(wdata)));
endmodule

// File: rtl/pinmap_split.sv
module pinmap_split
    import pinmap_pkg::*;
(
    input  logic [FIELD_W-1:0] field,
    input  logic [FCNT_W-1:0]  ss_cnt,
    input  logic               gate_mode,
    output logic               ss_apply,
    output logic [FCNT_W-1:0]  ss_n,
    output logic [FIELD_W-1:0] ss_bits,
    output logic [FIELD_W-1:0] dly
);
    logic [FCNT_W-1:0]  n;
    logic [FCNT_W-1:0]  dl;
    logic [FIELD_W:0]   lowmask;
    logic [FIELD_W-1:0] raw;
    logic [FIELD_W:0]   datamask;

    always_comb begin
        n        = clamp_f(ss_cnt);
        dl       = FCNT_W'(FIELD_W) - n;
        lowmask  = ((FIELD_W+1)'(1) << dl) - (FIELD_W+1)'(1);
        dly      = field & lowmask[FIELD_W-1:0];
        raw      = field >> dl;
        if (gate_mode && n != '0) begin
            ss_apply = field[FIELD_W-1];
            ss_n     = n - FCNT_W'(1);
        end else begin
            ss_apply = (n != '0);
            ss_n     = n;
        end
        datamask = ((FIELD_W+1)'(1) << ss_n) - (FIELD_W+1)'(1);
        ss_bits  = raw & datamask[FIELD_W-1:0];
    end

    always_comb begin
        if (int'(ss_cnt) >= FIELD_W)
            p_full_side_nodelay_r5: assert (dly == '0);
    end
endmodule

// File: rtl/pinmap_delay.sv
module pinmap_delay
    import pinmap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FIELD_W-1:0] dly,
    output logic               stall
);
    logic [FIELD_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= dly;
        else if (cnt_q != '0)  cnt_q <= cnt_q - FIELD_W'(1);
    end

    assign stall = (cnt_q != '0);

    p_stall_starts_r8: assert property (@(posedge clk) disable iff (rst)
        (load && dly != '0) |=> stall);
    p_no_stall_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (load && dly == '0) |=> !stall);
endmodule

// File: rtl/pinmap_unit.sv
module pinmap_unit
    import pinmap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic               ins_valid,
    input  logic [2:0]         ins_op,
    input  logic [PIN_W-1:0]   wr_data,
    input  logic [FIELD_W-1:0] ins_field,
    input  logic               ss_gate,
    input  logic [PIN_W-1:0]   pins_in,
    output logic [PIN_W-1:0]   in_view,
    output logic [PIN_W-1:0]   pin_val,
    output logic [PIN_W-1:0]   pin_dir,
    output logic               stall
);
    cfg_t               cfg;
    logic               ss_apply;
    logic [FCNT_W-1:0]  ss_n;
    logic [FIELD_W-1:0] ss_bits;
    logic [FIELD_W-1:0] dly;
    logic               accept;
    wr_t                wide_w, nar_w, side_w;
    logic [PIN_W-1:0]   nxt_val, nxt_dir;
    logic [PIN_W-1:0]   val_q, dir_q;

    pinmap_cfg u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
        .cfg(cfg), .rdata(cfg_rdata)
    );

    pinmap_split u_split (
        .field(ins_field), .ss_cnt(cfg.ss_cnt), .gate_mode(ss_gate),
        .ss_apply(ss_apply), .ss_n(ss_n), .ss_bits(ss_bits), .dly(dly)
    );

    assign accept = ins_valid && !stall;

    pinmap_delay u_delay (
        .clk(clk), .rst(rst), .load(accept), .dly(dly), .stall(stall)
    );

    always_comb begin
        wide_w.mask = win_mask(cfg.wide_base, cfg.wide_cnt);
        wide_w.data = rotl(wr_data, cfg.wide_base);
        nar_w.mask  = win_mask(cfg.nar_base, WCNT_W'(clamp_f(cfg.nar_cnt)));
        nar_w.data  = rotl({{(PIN_W-FIELD_W){1'b0}}, wr_data[FIELD_W-1:0]}, cfg.nar_base);
        side_w.mask = ss_apply ? win_mask(cfg.ss_base, WCNT_W'(ss_n)) : '0;
        side_w.data = rotl({{(PIN_W-FIELD_W){1'b0}}, ss_bits}, cfg.ss_base);

        nxt_val = val_q;
        nxt_dir = dir_q;
        case (ins_op)
            OP_WIDE_VAL: nxt_val = (val_q & ~wide_w.mask) | (wide_w.data & wide_w.mask);
            OP_WIDE_DIR: nxt_dir = (dir_q & ~wide_w.mask) | (wide_w.data & wide_w.mask);
            OP_NAR_VAL:  nxt_val = (val_q & ~nar_w.mask)  | (nar_w.data & nar_w.mask);
            OP_NAR_DIR:  nxt_dir = (dir_q & ~nar_w.mask)  | (nar_w.data & nar_w.mask);
            default: ;
        endcase
        nxt_val = (nxt_val & ~side_w.mask) | (side_w.data & side_w.mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
            dir_q <= '0;
        end else if (accept) begin
            val_q <= nxt_val;
            dir_q <= nxt_dir;
        end
    end

    assign pin_val = val_q;
    assign pin_dir = dir_q;
    assign in_view = rotr(pins_in, cfg.in_base);

    p_hold_in_stall_r9: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(pin_val) && $stable(pin_dir)));
    p_dir_untouched_r11: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && (ins_op == 3'd0 || ins_op == 3'd1 || ins_op == 3'd3 || ins_op > 3'd4))
        |=> $stable(pin_dir));
endmodule

// File: tb/pinmap_unit_bench.sv
`timescale 1ns/1ps
module pinmap_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        ins_valid = 1'b0;
    logic [2:0]  ins_op = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  ins_field = '0;
    logic        ss_gate = 1'b0;
    logic [31:0] pins_in = '0;
    logic [31:0] in_view, pin_val, pin_dir;
    logic        stall;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R1";

    logic [31:0] m_cfg, m_val, m_dir;
    int m_cnt;

    always #2.5 clk = ~clk;

    pinmap_unit u_pinmap_unit (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ins_valid(ins_valid), .ins_op(ins_op),
        .wr_data(wr_data), .ins_field(ins_field), .ss_gate(ss_gate),
        .pins_in(pins_in), .in_view(in_view), .pin_val(pin_val),
        .pin_dir(pin_dir), .stall(stall)
    );

    function automatic int fld(logic [31:0] c, int lo, int w);
        return int'((c >> lo) & ((32'd1 << w) - 1));
    endfunction

    // reference model, behavioural
    always @(posedge clk) begin
        if (rst) begin
            m_cfg = 32'h1400_0000; m_val = 0; m_dir = 0; m_cnt = 0;
        end else begin
            if (ins_valid && m_cnt == 0) begin
                int wb, nb, sb, wc, nc, sc, n, dl, raw, dn, en, bits;
                wb = fld(m_cfg, 0, 5);  nb = fld(m_cfg, 5, 5);
                sb = fld(m_cfg, 10, 5); wc = fld(m_cfg, 20, 6);
                nc = fld(m_cfg, 26, 3); sc = fld(m_cfg, 29, 3);
                if (wc > 32) wc = 32;
                if (nc > 5) nc = 5;
                n = (sc > 5) ? 5 : sc;
                case (ins_op)
                    3'd1: for (int i = 0; i < wc; i++) m_val[(wb+i)%32] = wr_data[i];
                    3'd2: for (int i = 0; i < wc; i++) m_dir[(wb+i)%32] = wr_data[i];
                    3'd3: for (int i = 0; i < nc; i++) m_val[(nb+i)%32] = wr_data[i];
                    3'd4: for (int i = 0; i < nc; i++) m_dir[(nb+i)%32] = wr_data[i];
                    default: ;
                endcase
                dl = 5 - n;
                raw = int'(ins_field) >> dl;
                if (ss_gate && n > 0) begin
                    en = int'(ins_field[4]); dn = n - 1;
                end else begin
                    en = (n > 0) ? 1 : 0; dn = n;
                end
                bits = raw & ((1 << dn) - 1);
                if (en != 0)
                    for (int i = 0; i < dn; i++) m_val[(sb+i)%32] = bits[i];
                m_cnt = int'(ins_field) % (1 << dl);
            end else if (m_cnt > 0) begin
                m_cnt = m_cnt - 1;
            end
            if (cfg_we) m_cfg = cfg_wdata;
        end
    end

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [31:0] ev;
            for (int i = 0; i < 32; i++) ev[i] = pins_in[(fld(m_cfg, 15, 5) + i) % 32];
            chk(cfg_rdata == m_cfg, "R2", "cfg_rdata", cfg_rdata, m_cfg);
            chk(pin_val == m_val, cur_req, "pin_val", pin_val, m_val);
            chk(pin_dir == m_dir, cur_req, "pin_dir", pin_dir, m_dir);
            chk(stall == (m_cnt != 0), "R8", "stall", 32'(stall), 32'(m_cnt != 0));
            chk(in_view == ev, "R10", "in_view", in_view, ev);
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    function automatic logic [31:0] mk(int wb, int nb, int sb, int ib, int wc, int nc, int sc);
        return (32'(sc) << 29) | (32'(nc) << 26) | (32'(wc) << 20) | (32'(ib) << 15)
             | (32'(sb) << 10) | (32'(nb) << 5) | 32'(wb);
    endfunction

    task automatic wcfg(logic [31:0] v);
        cfg_we = 1; cfg_wdata = v; step(); cfg_we = 0;
    endtask

    task automatic put(logic [2:0] op, logic [31:0] d, logic [4:0] f);
        ins_valid = 1; ins_op = op; wr_data = d; ins_field = f; step();
        ins_valid = 0;
    endtask

    task automatic ins(logic [2:0] op, logic [31:0] d, logic [4:0] f);
        put(op, d, f);
        while (stall) step();
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 0;
        #1;
        // R1 reset state
        chk(cfg_rdata == 32'h1400_0000, "R1", "reset cfg", cfg_rdata, 32'h1400_0000);
        chk(pin_val == 0, "R1", "reset pin_val", pin_val, 0);
        chk(pin_dir == 0, "R1", "reset pin_dir", pin_dir, 0);
        chk(stall == 0, "R1", "reset stall", 32'(stall), 0);
        step();

        cur_req = "R2";
        wcfg(mk(3, 4, 5, 6, 7, 2, 1));
        wcfg(32'hDEAD_BEEF);
        step(2);

        cur_req = "R3";
        wcfg(mk(30, 0, 0, 0, 4, 0, 0));
        ins(3'd1, 32'h0000_00A5, 5'd0);
        ins(3'd2, 32'h0000_000F, 5'd0);
        wcfg(mk(7, 0, 0, 0, 32, 0, 0));
        ins(3'd1, 32'h1234_5678, 5'd0);
        wcfg(mk(7, 0, 0, 0, 0, 0, 0));
        ins(3'd1, 32'hFFFF_FFFF, 5'd0);
        wcfg(mk(2, 0, 0, 0, 40, 0, 0));
        ins(3'd2, 32'hCAFE_F00D, 5'd0);

        cur_req = "R4";
        wcfg(mk(0, 29, 0, 0, 0, 5, 0));
        ins(3'd3, 32'hFFFF_FFF5, 5'd0);
        wcfg(mk(0, 10, 0, 0, 0, 7, 0));
        ins(3'd4, 32'h0000_001B, 5'd0);
        wcfg(mk(0, 10, 0, 0, 0, 2, 0));
        ins(3'd3, 32'h0000_0000, 5'd0);

        cur_req = "R5";
        for (int c = 0; c < 8; c++) begin
            wcfg(mk(0, 0, 30, 0, 0, 0, c));
            ins(3'd0, 0, 5'b10101);
            ins(3'd0, 0, 5'b01011);
        end

        cur_req = "R6";
        ss_gate = 1;
        wcfg(mk(0, 0, 12, 0, 0, 0, 3));
        ins(3'd0, 0, 5'b01100);
        ins(3'd0, 0, 5'b11100);
        ins(3'd0, 0, 5'b10000);
        wcfg(mk(0, 0, 12, 0, 0, 0, 1));
        ins(3'd0, 0, 5'b10000);
        ss_gate = 0;

        cur_req = "R7";
        wcfg(mk(8, 8, 9, 0, 8, 5, 2));
        ins(3'd1, 32'h0000_00FF, 5'b00000);
        ins(3'd3, 32'h0000_0000, 5'b11000);

        cur_req = "R8";
        wcfg(mk(0, 0, 0, 0, 1, 1, 0));
        ins(3'd1, 1, 5'd1);
        ins(3'd1, 0, 5'd31);
        wcfg(mk(0, 0, 0, 0, 1, 1, 3));
        ins(3'd0, 0, 5'b00011);
        wcfg(mk(0, 0, 0, 0, 1, 1, 5));
        ins(3'd0, 0, 5'b11111);

        cur_req = "R9";
        wcfg(mk(0, 0, 0, 0, 8, 1, 0));
        put(3'd1, 32'h0000_0055, 5'd6);
        put(3'd1, 32'h0000_00AA, 5'd0);
        put(3'd2, 32'h0000_00FF, 5'd0);
        step(8);

        cur_req = "R10";
        pins_in = 32'h8000_0001;
        for (int b = 0; b < 32; b += 5) begin
            wcfg(mk(0, 0, 0, b, 0, 0, 0));
            step();
        end
        pins_in = 32'h0F0F_3C5A;
        wcfg(mk(0, 0, 0, 31, 0, 0, 0));
        step();

        cur_req = "R11";
        wcfg(mk(0, 0, 0, 0, 32, 5, 0));
        ins(3'd0, 32'hFFFF_FFFF, 5'd0);
        ins(3'd5, 32'h0000_0000, 5'd0);
        ins(3'd6, 32'h1111_1111, 5'd0);
        ins(3'd7, 32'h0000_0000, 5'd0);

        cur_req = "R3/R4/R5/R7";
        for (int k = 0; k < 600; k++) begin
            if (($urandom % 5) == 0) begin
                cfg_we = 1; cfg_wdata = $urandom;
            end else cfg_we = 0;
            ins_valid = ($urandom % 3) != 0;
            ins_op = 3'($urandom);
            wr_data = $urandom;
            ins_field = ($urandom % 2) ? 5'($urandom) : 5'($urandom % 4);
            ss_gate = 1'($urandom);
            pins_in = $urandom;
            step();
        end
        cfg_we = 0; ins_valid = 0;
        step(40);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule